// File: doc/BRIEF.md
# Synchronous FIFO with Programmable Level Flags

This block is a single-clock FIFO that passes words in one direction. It has a write port and a read port, and each port has its own enable. The flags show whether a word can be read, whether a word can be written, and whether the fill level is near either end.

Two inputs are sampled only while master reset is held. The first picks the read timing: standard or first-word-fall-through. The second picks where the almost-empty and almost-full offsets come from. They can come from one of five built-in values, from a serial bit stream, or from the first two words written after reset.

A partial reset empties the queue and keeps the latched configuration. A mark/return pair lets the consumer go back and read a stretch of already-read words again.

Top module: `prog_flag_fifo`

## Requirements
- R1: While `mrst_n` is low the queue is emptied, and `fwft_sel_i` and `ofs_src_i` are latched. After release, changes on those two inputs have no effect. The first cycle after release shows `rd_avail_o`=0, `wr_room_o`=1, `almost_empty_o`=1 and `almost_full_o`=0 (for offsets below DEPTH).
- R2: The `ofs_src_i` codes select the offsets as follows. Codes 0, 1, 2, 3 and 4 load both offsets with 8, 16, 64, 256 and 1024. Code 5 selects the serial load and code 6 selects the parallel load. Code 7 behaves as code 0.
- R3: `almost_empty_o` is high when the level is at or below the empty offset. The level is the number of words in the memory array, plus the output word in fall-through mode when that word is valid. `almost_full_o` is high when DEPTH minus the words in the array is at or below the full offset.
- R4: Standard timing. `rd_avail_o` is high when the array holds a word. A read accepted at a clock edge puts the oldest word on `rd_data_o` after that edge, and the output changes only on an accepted read.
- R5: Fall-through timing. A word written into an empty queue appears on `rd_data_o` with `rd_avail_o` high one edge after the write edge, without any read. A read while `rd_avail_o` is high removes that word and presents the next one after the same edge.
- R6: `wr_room_o` is low when DEPTH words are in the array. A write in that state is dropped and the write pointer does not move.
- R7: A read while `rd_avail_o` is low is ignored. `rd_data_o` keeps its value and no later word is lost.
- R8: A write and a read at the same edge both take effect.
- R9: With code 5, each edge with `ser_en_i` high shifts `ser_d_i` in, most significant bit first. The first OFS_W bits form the empty offset and the next OFS_W bits form the full offset. Any further bits are ignored.
- R10: With code 6, the first two accepted writes after master reset are not stored. Bits [OFS_W-1:0] of the first one load the empty offset, and the same bits of the second one load the full offset.
- R11: While `prst_n` is low the queue and the retransmit mark are cleared. The timing mode, the offsets and a completed parallel load are all kept.
- R12: `rt_mark_i` records the current read position. `rt_go_i` moves the read position back to the recorded one, drops a pending fall-through word, and ignores a read in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst_n | input | 1 | Master reset, active low, synchronous |
| prst_n | input | 1 | Partial reset, active low, synchronous |
| fwft_sel_i | input | 1 | 1 selects fall-through timing (sampled during master reset) |
| ofs_src_i | input | 3 | Offset source code (sampled during master reset) |
| ser_en_i | input | 1 | Serial offset shift enable |
| ser_d_i | input | 1 | Serial offset data bit |
| wr_en_i | input | 1 | Write request |
| wr_data_i | input | DATA_W | Write data |
| rd_en_i | input | 1 | Read request |
| rd_data_o | output | DATA_W | Read data |
| rt_mark_i | input | 1 | Record the read position |
| rt_go_i | input | 1 | Return the read position to the mark |
| rd_avail_o | output | 1 | Data can be read (not-empty / output-ready) |
| wr_room_o | output | 1 | Data can be written (not-full / input-ready) |
| almost_empty_o | output | 1 | Level at or below the empty offset |
| almost_full_o | output | 1 | Free space at or below the full offset |

## Verification
The bench checks the almost-flag edges one word on each side of the offset, so a comparator that uses strictly-less-than, or the wrong offset source, moves a flag by one write. In fall-through mode the bench checks the one-edge delay before the first word appears and counts the output word in the level; a design that leaves that word out clears almost-empty one word late. The bench also confirms that parallel-load words never come out of the queue, that a partial reset keeps the loaded offsets, and that a dropped write or read does not move a pointer. Finally it confirms that a return after a mark replays the same words, even when a read arrives in the same cycle as the return.

// File: rtl/pff_pkg.sv
package pff_pkg;

   typedef enum logic [2:0] {
      OS_D8       = 3'd0,
      OS_D16      = 3'd1,
      OS_D64      = 3'd2,
      OS_D256     = 3'd3,
      OS_D1K      = 3'd4,
      OS_SERIAL   = 3'd5,
      OS_PARALLEL = 3'd6,
      OS_SPARE    = 3'd7
   } ofs_src_e;

   // built-in offset for a default code (spare code falls back to 8)
   function automatic logic [15:0] dflt_ofs(input ofs_src_e s);
      case (s)
         OS_D16:  return 16'd16;
         OS_D64:  return 16'd64;
         OS_D256: return 16'd256;
         OS_D1K:  return 16'd1024;
         default: return 16'd8;
      endcase
   endfunction

endpackage

// File: rtl/pff_cfg.sv
module pff_cfg
   import pff_pkg::*;
#(
   parameter int OFS_W = 11
) (
   input  logic             clk,
   input  logic             mrst_n,
   input  logic             fwft_sel_i,
   input  logic [2:0]       ofs_src_i,
   input  logic             ser_en_i,
   input  logic             ser_d_i,
   input  logic             wr_en_i,
   input  logic [OFS_W-1:0] wr_low_i,
   output logic             fwft_o,
   output logic             par_cap_o,
   output logic [OFS_W-1:0] ae_ofs_o,
   output logic [OFS_W-1:0] af_ofs_o
);

   localparam int SBITS = 2 * OFS_W;
   localparam int BCW   = $clog2(SBITS + 1);

   ofs_src_e         src_q;
   logic             fwft_q;
   logic [BCW-1:0]   bcnt_q;
   logic [1:0]       pcnt_q;
   logic [OFS_W-1:0] ae_q, af_q;

   assign par_cap_o = (src_q == OS_PARALLEL) && (pcnt_q != 2'd2);
   assign fwft_o    = fwft_q;
   assign ae_ofs_o  = ae_q;
   assign af_ofs_o  = af_q;

   always_ff @(posedge clk) begin
      if (!mrst_n) begin
         src_q  <= ofs_src_e'(ofs_src_i);
         fwft_q <= fwft_sel_i;
         bcnt_q <= '0;
         pcnt_q <= '0;
         if (ofs_src_e'(ofs_src_i) == OS_SERIAL || ofs_src_e'(ofs_src_i) == OS_PARALLEL) begin
            ae_q <= '0;
            af_q <= '0;
         end else begin
            ae_q <= OFS_W'(dflt_ofs(ofs_src_e'(ofs_src_i)));
            af_q <= OFS_W'(dflt_ofs(ofs_src_e'(ofs_src_i)));
         end
      end else begin
         if (src_q == OS_SERIAL && ser_en_i && bcnt_q < BCW'(SBITS)) begin
            {ae_q, af_q} <= {ae_q[OFS_W-2:0], af_q, ser_d_i};
            bcnt_q       <= bcnt_q + 1'b1;
         end
         if (par_cap_o && wr_en_i) begin
            if (pcnt_q == 2'd0) ae_q <= wr_low_i;
            else                af_q <= wr_low_i;
            pcnt_q <= pcnt_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/pff_ram.sv
module pff_ram #(
   parameter int DATA_W = 36,
   parameter int AW     = 6
) (
   input  logic              clk,
   input  logic              we_i,
   input  logic [AW-1:0]     waddr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [AW-1:0]     raddr_i,
   output logic [DATA_W-1:0] rdata_o
);

   localparam int WORDS = 1 << AW;

   logic [DATA_W-1:0] mem_q [WORDS];

   always_ff @(posedge clk) begin
      if (we_i) mem_q[waddr_i] <= wdata_i;
   end

   assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/pff_level.sv
module pff_level #(
   parameter int DEPTH = 64,
   parameter int OFS_W = 11
) (
   input  logic [$clog2(DEPTH):0] cnt_i,
   input  logic                   head_i,
   input  logic [OFS_W-1:0]       ae_ofs_i,
   input  logic [OFS_W-1:0]       af_ofs_i,
   output logic                   ae_o,
   output logic                   af_o
);

   localparam int PW = $clog2(DEPTH) + 1;

   logic [31:0] level, space;

   assign level = 32'(cnt_i) + 32'(head_i);
   assign space = 32'(PW'(DEPTH) - cnt_i);
   assign ae_o  = level <= 32'(ae_ofs_i);
   assign af_o  = space <= 32'(af_ofs_i);

endmodule

// File: rtl/prog_flag_fifo.sv
module prog_flag_fifo
   import pff_pkg::*;
#(
   parameter int DATA_W = 36,
   parameter int DEPTH  = 64,
   parameter int OFS_W  = 11
) (
   input  logic              clk,
   input  logic              mrst_n,
   input  logic              prst_n,
   input  logic              fwft_sel_i,
   input  logic [2:0]        ofs_src_i,
   input  logic              ser_en_i,
   input  logic              ser_d_i,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              rd_en_i,
   output logic [DATA_W-1:0] rd_data_o,
   input  logic              rt_mark_i,
   input  logic              rt_go_i,
   output logic              rd_avail_o,
   output logic              wr_room_o,
   output logic              almost_empty_o,
   output logic              almost_full_o
);

   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;

   generate
      if ((1 << AW) != DEPTH) begin : g_bad_depth
         $error("DEPTH must be a power of two");
      end
      if (OFS_W < 11 || OFS_W > 16) begin : g_bad_ofs
         $error("OFS_W must lie in 11..16");
      end
      if (DATA_W < OFS_W) begin : g_bad_width
         $error("DATA_W must cover an offset for the parallel load");
      end
   endgenerate

   logic              fwft_q, par_cap;
   logic [OFS_W-1:0]  ae_ofs, af_ofs;
   logic [PW-1:0]     wptr_q, rptr_q, mark_q, cnt;
   logic              ov_q;
   logic [DATA_W-1:0] dout_q, ram_rd;
   logic              ram_has, ram_full, wr_take, rd_take, fw_load;

   pff_cfg #(.OFS_W(OFS_W)) cfg_i (
      .clk       (clk),
      .mrst_n    (mrst_n),
      .fwft_sel_i(fwft_sel_i),
      .ofs_src_i (ofs_src_i),
      .ser_en_i  (ser_en_i),
      .ser_d_i   (ser_d_i),
      .wr_en_i   (wr_en_i),
      .wr_low_i  (wr_data_i[OFS_W-1:0]),
      .fwft_o    (fwft_q),
      .par_cap_o (par_cap),
      .ae_ofs_o  (ae_ofs),
      .af_ofs_o  (af_ofs)
   );

   assign cnt      = wptr_q - rptr_q;
   assign ram_has  = cnt != '0;
   assign ram_full = cnt == PW'(DEPTH);
   assign wr_take  = wr_en_i && !par_cap && !ram_full;
   assign fw_load  = ram_has && (!ov_q || rd_en_i) && !rt_go_i;
   assign rd_take  = fwft_q ? fw_load : (rd_en_i && ram_has && !rt_go_i);

   pff_ram #(.DATA_W(DATA_W), .AW(AW)) ram_i (
      .clk    (clk),
      .we_i   (wr_take),
      .waddr_i(wptr_q[AW-1:0]),
      .wdata_i(wr_data_i),
      .raddr_i(rptr_q[AW-1:0]),
      .rdata_o(ram_rd)
   );

   always_ff @(posedge clk) begin
      if (!mrst_n || !prst_n) begin
         wptr_q <= '0;
         rptr_q <= '0;
         mark_q <= '0;
         ov_q   <= 1'b0;
         dout_q <= '0;
      end else begin
         if (wr_take) wptr_q <= wptr_q + 1'b1;
         if (rt_mark_i) mark_q <= rptr_q;
         if (rt_go_i)      rptr_q <= mark_q;
         else if (rd_take) rptr_q <= rptr_q + 1'b1;
         if (rd_take) dout_q <= ram_rd;
         if (fwft_q) begin
            if (rt_go_i)      ov_q <= 1'b0;
            else if (fw_load) ov_q <= 1'b1;
            else if (rd_en_i) ov_q <= 1'b0;
         end
      end
   end

   pff_level #(.DEPTH(DEPTH), .OFS_W(OFS_W)) lvl_i (
      .cnt_i   (cnt),
      .head_i  (fwft_q && ov_q),
      .ae_ofs_i(ae_ofs),
      .af_ofs_i(af_ofs),
      .ae_o    (almost_empty_o),
      .af_o    (almost_full_o)
   );

   assign rd_data_o  = dout_q;
   assign rd_avail_o = fwft_q ? ov_q : ram_has;
   assign wr_room_o  = !ram_full;

endmodule

// File: rtl/pff_chk.sv
module pff_chk #(
   parameter int DEPTH = 64
) (
   input logic                   clk,
   input logic                   mrst_n,
   input logic                   prst_n,
   input logic                   wr_en,
   input logic                   rd_en,
   input logic                   rt_go,
   input logic                   fwft,
   input logic                   wr_room,
   input logic                   rd_avail,
   input logic [$clog2(DEPTH):0] wptr,
   input logic [$clog2(DEPTH):0] rptr,
   input logic [$clog2(DEPTH):0] mark
);

   localparam int PW = $clog2(DEPTH) + 1;

   logic [PW-1:0] fill;
   assign fill = wptr - rptr;

   // R6
   no_overflow_chk: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
      (!wr_room && wr_en) |=> (wptr == $past(wptr)));

   // R6
   fill_bound_chk: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
      fill <= PW'(DEPTH));

   // R7
   no_underflow_chk: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
      (!fwft && !rd_avail && rd_en && !rt_go) |=> (rptr == $past(rptr)));

   // R12
   rt_return_chk: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
      rt_go |=> (rptr == $past(mark)));

   // R1
   mode_hold_chk: assert property (@(posedge clk) disable iff (!mrst_n)
      1'b1 |=> $stable(fwft));

endmodule

bind prog_flag_fifo pff_chk #(.DEPTH(DEPTH)) chk_i (
   .clk     (clk),
   .mrst_n  (mrst_n),
   .prst_n  (prst_n),
   .wr_en   (wr_en_i),
   .rd_en   (rd_en_i),
   .rt_go   (rt_go_i),
   .fwft    (fwft_q),
   .wr_room (wr_room_o),
   .rd_avail(rd_avail_o),
   .wptr    (wptr_q),
   .rptr    (rptr_q),
   .mark    (mark_q)
);

// File: tb/prog_flag_fifo_tb.sv
module prog_flag_fifo_tb_top;

   localparam int DATA_W = 36;
   localparam int DEPTH  = 64;
   localparam int OFS_W  = 11;

   logic              clk = 1'b0;
   logic              mrst_n = 1'b0, prst_n = 1'b1;
   logic              fwft_sel = 1'b0;
   logic [2:0]        ofs_src = 3'd0;
   logic              ser_en = 1'b0, ser_d = 1'b0;
   logic              wr_en = 1'b0, rd_en = 1'b0;
   logic [DATA_W-1:0] wr_data = '0;
   logic              rt_mark = 1'b0, rt_go = 1'b0;
   logic [DATA_W-1:0] rd_data;
   logic              rd_avail, wr_room, a_empty, a_full;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   prog_flag_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .OFS_W(OFS_W)) dut_i (
      .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .fwft_sel_i(fwft_sel),
      .ofs_src_i(ofs_src), .ser_en_i(ser_en), .ser_d_i(ser_d),
      .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_data_o(rd_data),
      .rt_mark_i(rt_mark), .rt_go_i(rt_go), .rd_avail_o(rd_avail),
      .wr_room_o(wr_room), .almost_empty_o(a_empty), .almost_full_o(a_full)
   );

   function automatic logic [DATA_W-1:0] val(input int k);
      return {4'hC, 32'(k * 32'h0001_0101 + 32'h55)};
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic idle();
      @(negedge clk);
   endtask

   task automatic mreset(input logic fw, input logic [2:0] src);
      @(negedge clk);
      mrst_n = 1'b0; fwft_sel = fw; ofs_src = src;
      repeat (2) @(negedge clk);
      mrst_n = 1'b1;
      fwft_sel = ~fw; ofs_src = 3'd4;
   endtask

   task automatic push(input logic [DATA_W-1:0] d);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pop();
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic t_reset_std();
      mreset(1'b0, 3'd0);
      chk("R1 avail", rd_avail, 0);
      chk("R1 room", wr_room, 1);
      chk("R1 ae", a_empty, 1);
      chk("R1 af", a_full, 0);
   endtask

   task automatic t_std_order();
      for (int k = 0; k < 8; k++) push(val(k));
      chk("R2 R3 ae at 8", a_empty, 1);
      chk("R4 no read yet", rd_data, 0);
      push(val(8));
      chk("R2 R3 ae at 9", a_empty, 0);
      chk("R1 mode latched (std)", rd_data, 0);
      for (int k = 0; k < 9; k++) begin
         pop();
         chk("R4 pop data", rd_data, val(k));
      end
      chk("R4 avail empty", rd_avail, 0);
      pop();
      chk("R7 dout kept", rd_data, val(8));
   endtask

   task automatic t_full();
      mreset(1'b0, 3'd7);
      for (int k = 0; k < 55; k++) push(val(100 + k));
      chk("R2 R3 af at 55", a_full, 0);
      push(val(155));
      chk("R2 R3 af at 56", a_full, 1);
      for (int k = 56; k < 64; k++) push(val(100 + k));
      chk("R6 room low", wr_room, 0);
      push(36'hBAD);
      for (int k = 0; k < 64; k++) begin
         pop();
         chk("R6 full drain", rd_data, val(100 + k));
      end
      chk("R6 extra dropped", rd_avail, 0);
   endtask

   task automatic t_same_edge();
      mreset(1'b0, 3'd0);
      push(val(200));
      wr_en = 1'b1; wr_data = val(201); rd_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
      chk("R8 read part", rd_data, val(200));
      chk("R8 write part", rd_avail, 1);
      pop();
      chk("R8 second word", rd_data, val(201));
      chk("R8 empty after", rd_avail, 0);
   endtask

   task automatic t_fwft();
      mreset(1'b1, 3'd1);
      chk("R1 fwft avail", rd_avail, 0);
      push(val(300));
      chk("R5 not yet", rd_avail, 0);
      idle();
      chk("R5 fall through avail", rd_avail, 1);
      chk("R5 fall through data", rd_data, val(300));
      for (int k = 1; k < 16; k++) push(val(300 + k));
      chk("R2 R3 fwft ae at 16", a_empty, 1);
      push(val(316));
      chk("R2 R3 fwft ae at 17", a_empty, 0);
      for (int k = 0; k < 17; k++) begin
         chk("R5 head", rd_data, val(300 + k));
         pop();
      end
      chk("R5 drained", rd_avail, 0);
      pop();
      chk("R7 fwft dout kept", rd_data, val(316));
   endtask

   task automatic t_serial();
      logic [2*OFS_W-1:0] bits;
      bits = {11'd20, 11'd10};
      mreset(1'b0, 3'd5);
      for (int i = 2 * OFS_W - 1; i >= 0; i--) begin
         ser_en = 1'b1; ser_d = bits[i];
         @(negedge clk);
      end
      for (int i = 0; i < 3; i++) begin
         ser_d = 1'b1;
         @(negedge clk);
      end
      ser_en = 1'b0;
      for (int k = 0; k < 20; k++) push(val(400 + k));
      chk("R9 ae at 20", a_empty, 1);
      push(val(420));
      chk("R9 ae at 21", a_empty, 0);
      for (int k = 21; k < 53; k++) push(val(400 + k));
      chk("R9 af at 53", a_full, 0);
      push(val(453));
      chk("R9 af at 54", a_full, 1);
   endtask

   task automatic t_parallel();
      mreset(1'b0, 3'd6);
      push(36'd5);
      push(36'd60);
      chk("R10 offsets not stored", rd_avail, 0);
      for (int k = 0; k < 3; k++) push(val(500 + k));
      chk("R10 af at 3", a_full, 0);
      push(val(503));
      chk("R10 af at 4", a_full, 1);
      push(val(504));
      chk("R10 ae at 5", a_empty, 1);
      push(val(505));
      chk("R10 ae at 6", a_empty, 0);
      pop();
      chk("R10 first stored word", rd_data, val(500));
   endtask

   task automatic t_partial();
      @(negedge clk);
      prst_n = 1'b0;
      @(negedge clk);
      prst_n = 1'b1;
      chk("R11 avail cleared", rd_avail, 0);
      chk("R11 room", wr_room, 1);
      for (int k = 0; k < 4; k++) push(val(600 + k));
      chk("R11 af kept", a_full, 1);
      push(val(604));
      chk("R11 ae at 5", a_empty, 1);
      push(val(605));
      chk("R11 ae kept", a_empty, 0);
      pop();
      chk("R11 no reload", rd_data, val(600));
   endtask

   task automatic t_retransmit();
      mreset(1'b0, 3'd0);
      for (int k = 0; k < 5; k++) push(val(700 + k));
      rt_mark = 1'b1;
      @(negedge clk);
      rt_mark = 1'b0;
      for (int k = 0; k < 3; k++) pop();
      chk("R12 before return", rd_data, val(702));
      rt_go = 1'b1; rd_en = 1'b1;
      @(negedge clk);
      rt_go = 1'b0; rd_en = 1'b0;
      chk("R12 read ignored", rd_data, val(702));
      for (int k = 0; k < 5; k++) begin
         pop();
         chk("R12 replay", rd_data, val(700 + k));
      end
      chk("R12 end", rd_avail, 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      t_reset_std();
      t_std_order();
      t_full();
      t_same_edge();
      t_fwft();
      t_serial();
      t_parallel();
      t_partial();
      t_retransmit();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule